// File: doc/BRIEF.md
# Raster Timing Generator with Cursor and Windowbox Regions

This block produces the timing skeleton of a progressive display raster at the pixel clock. It sweeps a horizontal and a vertical position counter over the whole raster (visible area plus porches and sync). For each pixel it drives horizontal sync, vertical sync, a data-enable and the pixel coordinates. Every value is registered, so all outputs for one pixel appear in the same cycle. The default geometry is 1920x1080 visible inside a 2200x1125 raster, meant for a 148.5 MHz pixel clock. Both syncs are active high. The porch and sync lengths are parameters.

Downstream pixel stages also receive a set of region flags. One flag marks the first visible pixel of a frame and another marks the last. A cursor flag is raised while the pixel lies inside a programmable hardware-cursor rectangle. A window flag is raised while the pixel lies inside a second programmable rectangle. That second rectangle lets a smaller framebuffer image, for example 1152x870, be shown centred on the native raster, and pixels outside it are painted with a background colour. Both rectangles are sampled once per frame, at its first pixel, so a frame never mixes two rectangle settings.

Top module: `vtg_top`

## Requirements
- R1: After reset the first output cycle carries coordinates (0,0). x then rises by one per clock up to H_TOTAL-1 and wraps to 0. On each wrap y rises by one up to V_TOTAL-1 and then wraps to 0.
- R2: de_o is 1 exactly when x_o < H_ACTIVE and y_o < V_ACTIVE.
- R3: hsync_o is 1 exactly when H_ACTIVE+H_FP <= x_o < H_ACTIVE+H_FP+H_SYNC. vsync_o is 1 for every pixel of the lines V_ACTIVE+V_FP <= y_o < V_ACTIVE+V_FP+V_SYNC. Both are active high.
- R4: frame_start_o is 1 only at (0,0). frame_end_o is 1 only at (H_ACTIVE-1, V_ACTIVE-1). Each is high for a single cycle per frame.
- R5: cursor_o is 1 exactly when de_o is 1 and cur_x <= x_o < cur_x+cur_w and cur_y <= y_o < cur_y+cur_h. Bounds are half-open and use the rectangle in force for the frame.
- R6: window_o is 1 exactly when de_o is 1 and win_x <= x_o < win_x+win_w and win_y <= y_o < win_y+win_h. The rectangle in force for the frame is used.
- R7: Both rectangles are captured on the clock edge that produces the (0,0) output. A change at any other time has no effect on cursor_o or window_o until the next frame start.
- R8: While rst_n is 0, every sync, enable and flag output is 0 and x_o and y_o are 0. All outputs for one pixel are presented in the same cycle.
- R9: A rectangle that reaches past the visible area is clipped to it. A rectangle with zero width or height never raises its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_x | input | XW | Cursor rectangle left column |
| cur_y | input | YW | Cursor rectangle top line |
| cur_w | input | XW | Cursor rectangle width in pixels |
| cur_h | input | YW | Cursor rectangle height in lines |
| win_x | input | XW | Windowbox left column |
| win_y | input | YW | Windowbox top line |
| win_w | input | XW | Windowbox width in pixels |
| win_h | input | YW | Windowbox height in lines |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| de_o | output | 1 | Visible-area data enable |
| x_o | output | XW | Raster column of the current pixel |
| y_o | output | YW | Raster line of the current pixel |
| frame_start_o | output | 1 | First visible pixel of the frame |
| frame_end_o | output | 1 | Last visible pixel of the frame |
| cursor_o | output | 1 | Pixel inside the cursor rectangle |
| window_o | output | 1 | Pixel inside the windowbox rectangle |

## Verification
The bench uses a reduced raster geometry and compares every output against its own pixel-by-pixel model. It first runs whole frames with a centred windowbox and a small cursor inside it, which separates porch, sync and blanking boundaries and checks the half-open rectangle edges. A second pattern rewrites both rectangles in the middle of a frame, which separates per-frame capture from pass-through of the inputs. A third pattern places the cursor across the bottom-right visible corner and gives the window zero width, which exposes missing clipping or a wrong empty-rectangle check. A reset in the middle of a frame confirms the zero state and a clean restart at the origin.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    // Per-pixel flag bundle registered together with the coordinates.
    typedef struct packed {
        logic hsync;
        logic vsync;
        logic de;
        logic fstart;
        logic fend;
        logic cursor;
        logic window;
    } vtg_flags_t;

    localparam int NUM_RECTS = 2;
    localparam int RECT_CURSOR = 0;
    localparam int RECT_WINDOW = 1;

endpackage

// File: rtl/vtg_raster.sv
module vtg_raster #(
    parameter int H_TOTAL = 2200,
    parameter int V_TOTAL = 1125,
    parameter int XW      = $clog2(H_TOTAL),
    parameter int YW      = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [XW-1:0] hc,
    output logic [YW-1:0] vc,
    output logic          at_origin
);

    localparam logic [XW-1:0] H_LAST = XW'(H_TOTAL - 1);
    localparam logic [YW-1:0] V_LAST = YW'(V_TOTAL - 1);

    typedef struct packed {
        logic [XW-1:0] h;
        logic [YW-1:0] v;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q.h == H_LAST) begin
            cnt_d.h = '0;
            cnt_d.v = (cnt_q.v == V_LAST) ? '0 : cnt_q.v + 1'b1;
        end else begin
            cnt_d.h = cnt_q.h + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hc        = cnt_q.h;
    assign vc        = cnt_q.v;
    assign at_origin = (cnt_q.h == '0) && (cnt_q.v == '0);

    AST_H_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (hc != H_LAST) |=> (hc == $past(hc) + 1'b1) && (vc == $past(vc))); // R1
    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (hc == H_LAST && vc == V_LAST) |=> at_origin); // R1

endmodule

// File: rtl/vtg_rect.sv
module vtg_rect #(
    parameter int XW = 12,
    parameter int YW = 11
) (
    input  logic [XW-1:0] px,
    input  logic [YW-1:0] py,
    input  logic [XW-1:0] rx,
    input  logic [YW-1:0] ry,
    input  logic [XW-1:0] rw,
    input  logic [YW-1:0] rh,
    output logic          hit
);

    // One extra bit so that origin plus size never wraps.
    logic [XW:0] x_end;
    logic [YW:0] y_end;

    always_comb begin
        x_end = {1'b0, rx} + {1'b0, rw};
        y_end = {1'b0, ry} + {1'b0, rh};
        hit   = ({1'b0, px} >= {1'b0, rx}) && ({1'b0, px} < x_end) &&
                ({1'b0, py} >= {1'b0, ry}) && ({1'b0, py} < y_end);
    end

endmodule

// File: rtl/vtg_top.sv
module vtg_top
    import vtg_pkg::*;
#(
    parameter int H_ACTIVE = 1920,
    parameter int H_FP     = 88,
    parameter int H_SYNC   = 44,
    parameter int H_BP     = 148,
    parameter int V_ACTIVE = 1080,
    parameter int V_FP     = 4,
    parameter int V_SYNC   = 5,
    parameter int V_BP     = 36,
    localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP,
    localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP,
    localparam int XW      = $clog2(H_TOTAL),
    localparam int YW      = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [XW-1:0] cur_x,
    input  logic [YW-1:0] cur_y,
    input  logic [XW-1:0] cur_w,
    input  logic [YW-1:0] cur_h,
    input  logic [XW-1:0] win_x,
    input  logic [YW-1:0] win_y,
    input  logic [XW-1:0] win_w,
    input  logic [YW-1:0] win_h,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          de_o,
    output logic [XW-1:0] x_o,
    output logic [YW-1:0] y_o,
    output logic          frame_start_o,
    output logic          frame_end_o,
    output logic          cursor_o,
    output logic          window_o
);

    localparam logic [XW-1:0] HA      = XW'(H_ACTIVE);
    localparam logic [XW-1:0] HS_ON   = XW'(H_ACTIVE + H_FP);
    localparam logic [XW-1:0] HS_OFF  = XW'(H_ACTIVE + H_FP + H_SYNC);
    localparam logic [XW-1:0] HA_LAST = XW'(H_ACTIVE - 1);
    localparam logic [YW-1:0] VA      = YW'(V_ACTIVE);
    localparam logic [YW-1:0] VS_ON   = YW'(V_ACTIVE + V_FP);
    localparam logic [YW-1:0] VS_OFF  = YW'(V_ACTIVE + V_FP + V_SYNC);
    localparam logic [YW-1:0] VA_LAST = YW'(V_ACTIVE - 1);

    typedef struct packed {
        logic [XW-1:0] x;
        logic [YW-1:0] y;
        logic [XW-1:0] w;
        logic [YW-1:0] h;
    } rect_t;

    typedef struct packed {
        rect_t [NUM_RECTS-1:0] shadow;
        vtg_flags_t            flags;
        logic [XW-1:0]         x;
        logic [YW-1:0]         y;
    } state_t;

    state_t st_d, st_q;

    logic [XW-1:0] hc;
    logic [YW-1:0] vc;
    logic          at_origin;

    vtg_raster #(
        .H_TOTAL (H_TOTAL),
        .V_TOTAL (V_TOTAL),
        .XW      (XW),
        .YW      (YW)
    ) u_raster (
        .clk       (clk),
        .rst_n     (rst_n),
        .hc        (hc),
        .vc        (vc),
        .at_origin (at_origin)
    );

    rect_t [NUM_RECTS-1:0] rect_in;
    rect_t [NUM_RECTS-1:0] rect_eff;
    logic  [NUM_RECTS-1:0] rect_hit;

    assign rect_in[RECT_CURSOR] = '{x: cur_x, y: cur_y, w: cur_w, h: cur_h};
    assign rect_in[RECT_WINDOW] = '{x: win_x, y: win_y, w: win_w, h: win_h};

    // New rectangles are taken only on the first pixel of a frame.
    for (genvar i = 0; i < NUM_RECTS; i++) begin : g_rect
        assign rect_eff[i] = at_origin ? rect_in[i] : st_q.shadow[i];

        vtg_rect #(
            .XW (XW),
            .YW (YW)
        ) u_rect (
            .px  (hc),
            .py  (vc),
            .rx  (rect_eff[i].x),
            .ry  (rect_eff[i].y),
            .rw  (rect_eff[i].w),
            .rh  (rect_eff[i].h),
            .hit (rect_hit[i])
        );
    end

    always_comb begin
        logic vis;
        st_d        = st_q;
        st_d.shadow = rect_eff;
        st_d.x      = hc;
        st_d.y      = vc;
        vis         = (hc < HA) && (vc < VA);

        st_d.flags.de     = vis;
        st_d.flags.hsync  = (hc >= HS_ON) && (hc < HS_OFF);
        st_d.flags.vsync  = (vc >= VS_ON) && (vc < VS_OFF);
        st_d.flags.fstart = at_origin;
        st_d.flags.fend   = (hc == HA_LAST) && (vc == VA_LAST);
        st_d.flags.cursor = vis && rect_hit[RECT_CURSOR];
        st_d.flags.window = vis && rect_hit[RECT_WINDOW];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hsync_o       = st_q.flags.hsync;
    assign vsync_o       = st_q.flags.vsync;
    assign de_o          = st_q.flags.de;
    assign x_o           = st_q.x;
    assign y_o           = st_q.y;
    assign frame_start_o = st_q.flags.fstart;
    assign frame_end_o   = st_q.flags.fend;
    assign cursor_o      = st_q.flags.cursor;
    assign window_o      = st_q.flags.window;

    AST_VSYNC_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsync_o) |-> (x_o == '0) && (y_o == VS_ON)); // R3
    AST_FSTART_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |=> !frame_start_o); // R4
    AST_FEND_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end_o |=> !de_o && !frame_end_o); // R4
    AST_CURSOR_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        cursor_o |-> de_o); // R5
    AST_WINDOW_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        window_o |-> de_o); // R6
    AST_RECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !at_origin |=> $stable(st_q.shadow)); // R7

endmodule

// File: tb/sim_vtg_top.sv
module sim_vtg_top;

    localparam int HA = 16, HFP = 2, HSY = 3, HBP = 4;
    localparam int VA = 8,  VFP = 1, VSY = 2, VBP = 3;
    localparam int HT = HA + HFP + HSY + HBP;
    localparam int VT = VA + VFP + VSY + VBP;
    localparam int XW = $clog2(HT);
    localparam int YW = $clog2(VT);
    localparam int FRAME = HT * VT;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [XW-1:0] cur_x, cur_w, win_x, win_w;
    logic [YW-1:0] cur_y, cur_h, win_y, win_h;
    logic hsync_o, vsync_o, de_o, frame_start_o, frame_end_o, cursor_o, window_o;
    logic [XW-1:0] x_o;
    logic [YW-1:0] y_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int ex = 0, ey = 0;
    int fcx, fcy, fcw, fch, fwx, fwy, fww, fwh;   // rectangles in force
    int ncx, ncy, ncw, nch, nwx, nwy, nww, nwh;   // pending mid-frame values

    always #5 clk = ~clk;

    vtg_top #(
        .H_ACTIVE (HA), .H_FP (HFP), .H_SYNC (HSY), .H_BP (HBP),
        .V_ACTIVE (VA), .V_FP (VFP), .V_SYNC (VSY), .V_BP (VBP)
    ) u0 (
        .clk (clk), .rst_n (rst_n),
        .cur_x (cur_x), .cur_y (cur_y), .cur_w (cur_w), .cur_h (cur_h),
        .win_x (win_x), .win_y (win_y), .win_w (win_w), .win_h (win_h),
        .hsync_o (hsync_o), .vsync_o (vsync_o), .de_o (de_o),
        .x_o (x_o), .y_o (y_o),
        .frame_start_o (frame_start_o), .frame_end_o (frame_end_o),
        .cursor_o (cursor_o), .window_o (window_o)
    );

    task automatic summary_and_end();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, cycles=%0d expected<=20000", cycles);
            summary_and_end();
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s at (%0d,%0d): actual=%0d expected=%0d",
                     req, what, ex, ey, act, exp);
        end
    endtask

    function automatic bit in_rect(int px, int py, int rx, int ry, int rw, int rh);
        return px >= rx && px < rx + rw && py >= ry && py < ry + rh;
    endfunction

    task automatic set_rects(int cx, int cy, int cw, int ch, int wx, int wy, int ww, int wh);
        cur_x = XW'(cx); cur_y = YW'(cy); cur_w = XW'(cw); cur_h = YW'(ch);
        win_x = XW'(wx); win_y = YW'(wy); win_w = XW'(ww); win_h = YW'(wh);
    endtask

    // Reset, release at a falling edge; next rising edge outputs (0,0).
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk({hsync_o, vsync_o, de_o, frame_start_o, frame_end_o, cursor_o, window_o} == 7'b0,
            "R8", "flags in reset",
            int'({hsync_o, vsync_o, de_o, frame_start_o, frame_end_o, cursor_o, window_o}), 0);
        chk(x_o == '0 && y_o == '0, "R8", "coords in reset", int'(x_o) * 100 + int'(y_o), 0);
        rst_n = 1'b1;
        ex = 0;
        ey = 0;
    endtask

    // Check n consecutive pixels; at index chg, apply the pending rectangle values.
    task automatic run_pixels(int n, int chg, string rtag);
        for (int c = 0; c < n; c++) begin
            bit vis, hs, vs;
            @(negedge clk);
            if (ex == 0 && ey == 0) begin
                fcx = int'(cur_x); fcy = int'(cur_y); fcw = int'(cur_w); fch = int'(cur_h);
                fwx = int'(win_x); fwy = int'(win_y); fww = int'(win_w); fwh = int'(win_h);
            end
            vis = (ex < HA) && (ey < VA);
            hs  = (ex >= HA + HFP) && (ex < HA + HFP + HSY);
            vs  = (ey >= VA + VFP) && (ey < VA + VFP + VSY);
            chk(int'(x_o) == ex, "R1", "x", int'(x_o), ex);
            chk(int'(y_o) == ey, "R1", "y", int'(y_o), ey);
            chk(de_o == vis, "R2", "de", int'(de_o), int'(vis));
            chk(hsync_o == hs, "R3", "hsync", int'(hsync_o), int'(hs));
            chk(vsync_o == vs, "R3", "vsync", int'(vsync_o), int'(vs));
            chk(frame_start_o == (ex == 0 && ey == 0), "R4", "frame_start",
                int'(frame_start_o), int'(ex == 0 && ey == 0));
            chk(frame_end_o == (ex == HA - 1 && ey == VA - 1), "R4", "frame_end",
                int'(frame_end_o), int'(ex == HA - 1 && ey == VA - 1));
            chk(cursor_o == (vis && in_rect(ex, ey, fcx, fcy, fcw, fch)),
                rtag, "cursor", int'(cursor_o), int'(vis && in_rect(ex, ey, fcx, fcy, fcw, fch)));
            chk(window_o == (vis && in_rect(ex, ey, fwx, fwy, fww, fwh)),
                rtag, "window", int'(window_o), int'(vis && in_rect(ex, ey, fwx, fwy, fww, fwh)));
            if (c == chg) set_rects(ncx, ncy, ncw, nch, nwx, nwy, nww, nwh);
            ex++;
            if (ex == HT) begin
                ex = 0;
                ey = (ey == VT - 1) ? 0 : ey + 1;
            end
        end
    endtask

    // R1 R2 R3 R4 R5 R6: centred windowbox with a cursor inside.
    task automatic test_centred();
        set_rects(5, 2, 2, 2, 3, 1, 10, 6);
        do_reset();
        run_pixels(2 * FRAME, -1, "R5 R6");
    endtask

    // R7: rectangles rewritten in mid-frame must wait for the next frame start.
    task automatic test_midframe();
        int hits;
        set_rects(1, 1, 3, 3, 3, 1, 10, 6);
        ncx = 9; ncy = 4; ncw = 3; nch = 2; nwx = 0; nwy = 0; nww = 16; nwh = 8;
        do_reset();
        run_pixels(FRAME / 2, 10, "R7");
        // (0,0) lies only in the new window; it must still be dark this frame.
        chk(fwx == 3 && fww == 10, "R7", "old window still in force", fwx, 3);
        run_pixels(FRAME - FRAME / 2 + FRAME, -1, "R7");
        hits = 0;
        chk(fwx == 0 && fww == 16 && fcx == 9, "R7", "new rects taken at frame start", fwx, 0);
        // One more visible line checked against the full-width window.
        run_pixels(HT, -1, "R7");
        hits = fww;
        chk(hits == 16, "R7", "window width in force", hits, 16);
    endtask

    // R9: cursor across the bottom-right corner, zero-width and zero-height windows.
    task automatic test_clip();
        set_rects(14, 6, 6, 5, 4, 2, 0, 4);
        do_reset();
        run_pixels(FRAME, -1, "R9");
        set_rects(14, 6, 6, 5, 4, 2, 6, 0);
        run_pixels(FRAME, -1, "R9");
    endtask

    // R8 R1: reset during a frame clears everything and restarts at the origin.
    task automatic test_reset_midway();
        set_rects(5, 2, 2, 2, 3, 1, 10, 6);
        run_pixels(FRAME / 3, -1, "R8");
        do_reset();
        run_pixels(FRAME + 5, -1, "R1");
    endtask

    initial begin
        set_rects(0, 0, 0, 0, 0, 0, 0, 0);
        test_centred();
        test_midframe();
        test_clip();
        test_reset_midway();
        summary_and_end();
    end

endmodule